// File: doc/BRIEF.md
# SPI ADC Scan Sequencer

This block is an SPI master that runs an external four-channel, 12-bit successive-approximation converter in a continuous scan. After every reset it opens one transaction that programs the converter's mode register with a fixed 16-bit word. From then on it only reads. Each later transaction is a 16-bit frame that returns one conversion result, tagged with the channel it came from.

Each decoded result goes out on a result stream made of `res_valid`, `res_chan` and `res_data`. The consumer answers with `res_ack`, which plays the role of a ready signal. A result stays on the stream until the consumer accepts it: the transfer takes place on the first clock edge at which `res_valid` and `res_ack` are both high. While a result is waiting, the sequencer starts no new frame. Back-pressure from the consumer therefore slows down the scan, and no data is lost.

Top module: `adc_scan_sequencer`

## Requirements
- R1: While `rst_n` is low, `adc_sck` is 1, `adc_cs_n` is 1 and `res_valid` is 0. After every release of reset, the first frame sends the configuration word again.
- R2: The first frame after reset shifts out 16'h21A4 on `adc_mosi`, MSB first. From the top bit down, the word holds: register-select 0, scan mode 4'b0100, last channel 4'b0011, FIFO reset 2'b01, power mode 2'b00, channel-tag enable 1, software-start 0, spare 0.
- R3: While `adc_cs_n` is low, `adc_mosi` changes only on the clock edge where `adc_sck` falls. The converter samples it on the rising edge.
- R4: Every frame has exactly 16 SCK rising edges. On each rising edge the sequencer samples `adc_miso`, building the frame word MSB first.
- R5: At the end of a data frame, `res_data` is frame bits [11:0] and `res_chan` is frame bits [13:12]. Frame bits [15:14] have no effect. Results come out in frame order.
- R6: `adc_mosi` is 0 throughout every data frame.
- R7: While `res_valid` is 1 and `res_ack` is 0, `res_valid`, `res_chan` and `res_data` stay unchanged. After an edge where `res_valid` and `res_ack` are both 1, `res_valid` is 0, so a result is never presented twice.
- R8: `adc_cs_n` never falls on an edge where `res_valid` was 1 just before that edge.
- R9: `adc_sck` is 1 whenever `adc_cs_n` is 1. Within a frame, consecutive SCK rising edges are exactly `CLK_DIV` clock cycles apart.
- R10: Between frames, `adc_cs_n` stays high for at least `GAP_SCK*CLK_DIV` clock cycles (2*`CLK_DIV` by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_miso | input | 1 | Serial data from the converter |
| adc_mosi | output | 1 | Serial data to the converter |
| adc_sck | output | 1 | Serial clock, idles high |
| adc_cs_n | output | 1 | Active-low chip select |
| res_chan | output | 2 | Channel tag of the presented result |
| res_data | output | 12 | Conversion value of the presented result |
| res_valid | output | 1 | A result is presented |
| res_ack | input | 1 | Consumer accepts the presented result (ready) |

## Verification
The first data values are chosen to catch bit-order and masking faults: all zeros, all ones, a lone MSB and a lone gap below it. The unused top tag bits are filled at random. A shifter that runs in the wrong direction or samples on the wrong SCK edge returns shuffled values, and a decoder that takes the wrong slice reports the wrong channel. Acknowledges come after random delays, and one result is held for hundreds of cycles. A design that overwrites a pending result or starts a frame under back-pressure breaks R7 or R8, and one that leaves valid high after the ack hands out the same result twice. Reset is pulled in the middle of a data frame. A design that remembers it was already configured would skip the second configuration word.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int FRAME_W = 16;
  localparam int DATA_W  = 12;
  localparam int CHAN_W  = 2;

  // mode register write: select, scan mode, last channel, fifo reset,
  // power mode, tag enable, software start, spare
  localparam logic [FRAME_W-1:0] CFG_WORD =
    {1'b0, 4'b0100, 4'b0011, 2'b01, 2'b00, 1'b1, 1'b0, 1'b0};

  typedef enum logic [0:0] {ST_GAP, ST_XFER} seq_state_t;
endpackage

// File: rtl/adc_seq_sckgen.sv
module adc_seq_sckgen #(
  parameter int CLK_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic fall_stb,
  output logic rise_stb,
  output logic end_stb
);
  localparam int CNT_W = $clog2(CLK_DIV);
  localparam int HALF  = CLK_DIV / 2;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt <= '0;
    else if (!run)                             cnt <= '0;
    else if (cnt == CNT_W'(CLK_DIV - 1))       cnt <= '0;
    else                                       cnt <= cnt + 1'b1;
  end

  assign fall_stb = run && (cnt == '0);
  assign rise_stb = run && (cnt == CNT_W'(HALF));
  assign end_stb  = run && (cnt == CNT_W'(CLK_DIV - 1));
endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift_out,
  input  logic         sample,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx      <= '0;
      mosi    <= 1'b0;
      rx_word <= '0;
    end else begin
      if (load) begin
        tx <= load_word;
      end else if (shift_out) begin
        mosi <= tx[W-1];
        tx   <= {tx[W-2:0], 1'b0};
      end
      if (sample) rx_word <= {rx_word[W-2:0], miso};
    end
  end
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result
  import adc_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [FRAME_W-1:0] frame,
  input  logic               ack,
  output logic               valid,
  output logic [CHAN_W-1:0]  chan,
  output logic [DATA_W-1:0]  data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      chan  <= '0;
      data  <= '0;
    end else if (capture) begin
      valid <= 1'b1;
      chan  <= frame[DATA_W +: CHAN_W];
      data  <= frame[DATA_W-1:0];
    end else if (valid && ack) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer
  import adc_seq_pkg::*;
#(
  parameter int CLK_DIV = 8,
  parameter int GAP_SCK = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_miso,
  output logic              adc_mosi,
  output logic              adc_sck,
  output logic              adc_cs_n,
  output logic [CHAN_W-1:0] res_chan,
  output logic [DATA_W-1:0] res_data,
  output logic              res_valid,
  input  logic              res_ack
);
  localparam int GAP_CYC = GAP_SCK * CLK_DIV;
  localparam int GAP_W   = $clog2(GAP_CYC);
  localparam int BIT_W   = $clog2(FRAME_W);

  seq_state_t         state;
  logic [GAP_W-1:0]   gap_cnt;
  logic [BIT_W-1:0]   bit_cnt;
  logic               cfg_sent;
  logic               fall_stb, rise_stb, end_stb;
  logic               gap_done, start, last_bit, capture;
  logic [FRAME_W-1:0] rx_word;
  logic [FRAME_W-1:0] tx_word;

  assign gap_done = (gap_cnt == GAP_W'(GAP_CYC - 1));
  assign start    = (state == ST_GAP) && gap_done && !res_valid;
  assign last_bit = end_stb && (bit_cnt == BIT_W'(FRAME_W - 1));
  assign capture  = last_bit && cfg_sent;
  assign tx_word  = cfg_sent ? '0 : CFG_WORD;

  adc_seq_sckgen #(.CLK_DIV(CLK_DIV)) u_sckgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state == ST_XFER),
    .fall_stb (fall_stb),
    .rise_stb (rise_stb),
    .end_stb  (end_stb)
  );

  adc_seq_shifter #(.W(FRAME_W)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_word (tx_word),
    .shift_out (fall_stb),
    .sample    (rise_stb),
    .miso      (adc_miso),
    .mosi      (adc_mosi),
    .rx_word   (rx_word)
  );

  adc_seq_result u_result (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .frame   (rx_word),
    .ack     (res_ack),
    .valid   (res_valid),
    .chan    (res_chan),
    .data    (res_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_GAP;
      gap_cnt  <= '0;
      bit_cnt  <= '0;
      cfg_sent <= 1'b0;
      adc_sck  <= 1'b1;
      adc_cs_n <= 1'b1;
    end else begin
      case (state)
        ST_GAP: begin
          if (!gap_done) gap_cnt <= gap_cnt + 1'b1;
          if (start) begin
            state    <= ST_XFER;
            adc_cs_n <= 1'b0;
            bit_cnt  <= '0;
          end
        end
        ST_XFER: begin
          if (fall_stb) adc_sck <= 1'b0;
          if (rise_stb) adc_sck <= 1'b1;
          if (last_bit) begin
            state    <= ST_GAP;
            adc_cs_n <= 1'b1;
            gap_cnt  <= '0;
            cfg_sent <= 1'b1;
          end else if (end_stb) begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        default: state <= ST_GAP;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int CLK_DIV = 8,
  parameter int GAP_SCK = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sck,
  input logic        cs_n,
  input logic        mosi,
  input logic        valid,
  input logic        ack,
  input logic [1:0]  chan,
  input logic [11:0] data,
  input logic        cfg_sent
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hi_cnt <= '0;
    else if (!cs_n)            hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
  end

  // R9
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sck);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ack |=> valid && $stable(chan) && $stable(data));

  // R7
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ack |=> !valid);

  // R8
  no_start_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !$fell(cs_n));

  // R6
  mosi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n && cfg_sent |-> !mosi);

  // R10
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_cnt >= 16'(GAP_SCK * CLK_DIV));
endmodule

bind adc_scan_sequencer adc_seq_checker #(.CLK_DIV(CLK_DIV), .GAP_SCK(GAP_SCK)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sck      (adc_sck),
  .cs_n     (adc_cs_n),
  .mosi     (adc_mosi),
  .valid    (res_valid),
  .ack      (res_ack),
  .chan     (res_chan),
  .data     (res_data),
  .cfg_sent (cfg_sent)
);

// File: tb/adc_scan_sequencer_bench.sv
`timescale 1ns/1ps
module adc_scan_sequencer_bench;
  localparam int CLK_DIV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adc_miso = 1'b0;
  logic        adc_mosi, adc_sck, adc_cs_n, res_valid;
  logic        res_ack = 1'b0;
  logic [1:0]  res_chan;
  logic [11:0] res_data;

  int n_chk = 0, n_fail = 0, cyc = 0, results_seen = 0;

  adc_scan_sequencer #(.CLK_DIV(CLK_DIV)) u_adc_scan_sequencer (
    .clk(clk), .rst_n(rst_n), .adc_miso(adc_miso), .adc_mosi(adc_mosi),
    .adc_sck(adc_sck), .adc_cs_n(adc_cs_n), .res_chan(res_chan),
    .res_data(res_data), .res_valid(res_valid), .res_ack(res_ack)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  function automatic logic [11:0] pick_value(input int idx);
    case (idx)
      0: return 12'h000;
      1: return 12'hFFF;
      2: return 12'h800;
      3: return 12'h7FF;
      default: return 12'($urandom);
    endcase
  endfunction

  // converter model
  logic [15:0] s_tx, s_rx;
  logic [13:0] s_cur;
  logic [13:0] exp_q[$];
  logic [1:0]  ch_next = 2'd0;
  int          s_rises = 0, n_data = 0, cfg_count = 0;
  bit          cfg_seen = 1'b0;

  always @(negedge adc_cs_n) if (rst_n) begin
    s_rises = 0;
    s_rx    = 16'h0;
    if (!cfg_seen) s_tx = 16'hFFFF;
    else begin
      s_cur = {ch_next, pick_value(n_data)};
      s_tx  = {2'($urandom), s_cur};
    end
  end

  always @(negedge adc_sck) if (rst_n && !adc_cs_n) begin
    adc_miso = s_tx[15];
    s_tx     = {s_tx[14:0], 1'b0};
  end

  always @(posedge adc_sck) if (rst_n && !adc_cs_n) begin
    s_rx = {s_rx[14:0], adc_mosi};
    s_rises++;
  end

  always @(posedge adc_cs_n) if (rst_n) begin
    chk(s_rises == 16, "R4", "sck rises per frame", s_rises, 16);
    if (!cfg_seen) begin
      chk(s_rx == 16'h21A4, "R2", "config word", s_rx, 16'h21A4);
      cfg_seen = 1'b1;
      cfg_count++;
    end else begin
      chk(s_rx == 16'h0, "R6", "mosi in data frame", s_rx, 16'h0);
      exp_q.push_back(s_cur);
      ch_next++;
      n_data++;
    end
  end

  // consumer with random back-pressure
  logic        p_valid = 1'b0, p_ack = 1'b0;
  logic [1:0]  p_chan;
  logic [11:0] p_data;
  int          ack_wait = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      res_ack = 1'b0; p_valid = 1'b0; p_ack = 1'b0; ack_wait = 0;
    end else begin
      if (p_valid && !p_ack)
        chk(res_valid && res_chan == p_chan && res_data == p_data, "R7",
            "held result", {res_valid, res_chan, res_data}, {1'b1, p_chan, p_data});
      if (p_valid && p_ack)
        chk(!res_valid, "R7", "valid after accept", res_valid, 0);
      if (res_ack) res_ack = 1'b0;
      else if (res_valid) begin
        if (ack_wait > 0) ack_wait--;
        else begin
          if (exp_q.size() == 0)
            chk(1'b0, "R5", "unexpected result", {res_chan, res_data}, 0);
          else begin
            logic [13:0] e;
            e = exp_q.pop_front();
            chk({res_chan, res_data} == e, "R5", "decoded result",
                {res_chan, res_data}, e);
          end
          res_ack = 1'b1;
          results_seen++;
          ack_wait = (results_seen == 10) ? 400 : int'($urandom_range(0, 6));
        end
      end
      p_valid = res_valid; p_ack = res_ack; p_chan = res_chan; p_data = res_data;
    end
  end

  // line monitor
  logic m_sck = 1'b1, m_cs = 1'b1, m_mosi = 1'b0, m_valid = 1'b0;
  int   hi_run = 0, last_rise = -1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (adc_cs_n) chk(adc_sck, "R9", "sck idle level", adc_sck, 1);
      if (!adc_cs_n && adc_mosi != m_mosi)
        chk(!adc_sck && m_sck, "R3", "mosi change at sck fall", {m_sck, adc_sck}, 2'b10);
      if (!adc_cs_n && m_cs) begin
        chk(hi_run >= 2 * CLK_DIV, "R10", "cs high gap", hi_run, 2 * CLK_DIV);
        chk(!m_valid, "R8", "frame start while pending", m_valid, 0);
        last_rise = -1;
      end
      if (!adc_cs_n && adc_sck && !m_sck) begin
        if (last_rise >= 0)
          chk(cyc - last_rise == CLK_DIV, "R9", "sck period", cyc - last_rise, CLK_DIV);
        last_rise = cyc;
      end
    end
    hi_run  = adc_cs_n ? hi_run + 1 : 0;
    m_sck   = adc_sck; m_cs = adc_cs_n; m_mosi = adc_mosi; m_valid = res_valid;
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(adc_sck && adc_cs_n && !res_valid, "R1", "reset state",
        {adc_sck, adc_cs_n, res_valid}, 3'b110);
    rst_n = 1'b1;
    while (results_seen < 40) @(negedge clk);
    // reset in the middle of a data frame
    while (adc_cs_n) @(negedge clk);
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(adc_sck && adc_cs_n && !res_valid, "R1", "reset mid frame",
        {adc_sck, adc_cs_n, res_valid}, 3'b110);
    cfg_seen = 1'b0; ch_next = 2'd0; exp_q.delete();
    rst_n = 1'b1;
    while (results_seen < 56) @(negedge clk);
    chk(cfg_count == 2, "R1", "config frames sent", cfg_count, 2);
    summary();
    $finish;
  end
endmodule